// File: doc/BRIEF.md
# PTP Timer Increment Calculator with Frequency Trim

This unit computes the per-cycle increment that a precision time counter adds on every tick of its reference clock. The increment is a fixed-point quantity: a whole-nanosecond field and a 24-bit binary fraction of a nanosecond. In the nominal (init) mode the unit derives the increment from the reference clock rate in hertz. In the trim mode it takes a signed frequency correction, expressed in parts per million with 16 fractional bits, and produces a corrected increment based on the stored nominal value.

All arithmetic is sequential. A shift-add multiplier and a restoring divider each retire one bit per clock, so the block needs no hardware multiplier or divider macro. A start pulse selects the mode and launches one computation. A one-cycle done pulse marks the moment the increment outputs take their new value. A zero rate in init mode is rejected with an error flag, and no computation takes place.

Top module: `ptp_inc_trimmer`

## Requirements
- R1: After reset, inc_ns_o, inc_frac_o, done_o and err_o are all zero.
- R2: A start with mode_i = 0 (init) and a nonzero rate computes W = floor(1e9 * 2^24 / rate) modulo 2^32. inc_ns_o = W[31:24] is the integer part of 1e9/rate kept to 8 bits. inc_frac_o = W[23:0] is floor(remainder * 2^24 / rate).
- R3: When the rate divides 1e9 exactly, inc_frac_o is zero and inc_ns_o is the quotient.
- R4: A start with mode_i = 1 (trim) and ppm_i >= 0 yields W = N + A modulo 2^32. N is the stored nominal word {ns, frac}. A = floor(((|ppm| * N) + 500000) / 2^16 / 1e6), where ppm_i is two's complement with 16 fraction bits. The shift by 16 is applied before the division.
- R5: A trim with ppm_i < 0 yields W = N - A modulo 2^32, where A uses the magnitude of ppm_i, including the most negative value.
- R6: Every trim starts from the nominal word of the last successful init, never from the increment currently on the outputs. A trim leaves the nominal word unchanged.
- R7: done_o is high for exactly one cycle. For init it is high in the 64th cycle after the clock edge that samples start_i. For trim it is high in the 96th cycle after that edge.
- R8: A start_i pulse that arrives while a computation is running is ignored. It causes no extra done_o pulse and does not alter the result.
- R9: An init start with rate 0 sets err_o in the next cycle. It produces no done_o, and it changes neither the outputs nor the nominal word. err_o clears at the next accepted start.
- R10: inc_ns_o and inc_frac_o change only in the cycle where done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a computation when idle |
| mode_i | input | 1 | 0 = nominal from rate, 1 = trim by ppm |
| rate_i | input | 32 | Reference clock rate in Hz |
| ppm_i | input | 32 | Signed correction, ppm with 16 fraction bits |
| inc_ns_o | output | 8 | Whole-nanosecond increment |
| inc_frac_o | output | 24 | Fractional increment, units of 2^-24 ns |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Set when init was requested with rate 0 |

## Verification
Several properties are checked on every cycle by assertions. The done pulse lasts a single cycle. The outputs hold still outside that pulse. No done appears while the error flag is up. The nominal word and the mode stay frozen during a trim. The divider remainder stays below its divisor. Only the bench scenarios can show the arithmetic itself. They cover exact and inexact rates, the extreme rates, positive, zero and most-negative corrections, and back-to-back trims that must both reference the nominal. The bench also covers the exact latency of each mode, a start pulse dropped while busy, and the zero-rate rejection with its later recovery.

// File: rtl/ptp_trim_pkg.sv
`timescale 1ns/1ps
package ptp_trim_pkg;

    // Fixed constants of the increment arithmetic
    localparam logic [63:0] NSEC_PER_SEC = 64'd1_000_000_000;
    localparam logic [63:0] ROUND_HALF   = 64'd500_000;
    localparam logic [63:0] SCALE_DIV    = 64'd1_000_000;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MUL  = 2'd1,
        PH_DIV  = 2'd2
    } phase_e;

endpackage

// File: rtl/ptp_trim_mul_step.sv
`timescale 1ns/1ps
// One shift-add multiply iteration: examines the low bit of the multiplier
// held in the lower half of the accumulator, then shifts right by one.
module ptp_trim_mul_step #(
    parameter int A_W = 32,
    parameter int B_W = 32,
    localparam int P_W = A_W + B_W
) (
    input  logic [P_W-1:0] acc_i,
    input  logic [A_W-1:0] mcand_i,
    output logic [P_W-1:0] acc_o
);
    logic [A_W-1:0] hi;
    logic [B_W-1:0] lo;
    logic [A_W:0]   sum;

    always_comb begin
        hi  = acc_i[P_W-1:B_W];
        lo  = acc_i[B_W-1:0];
        sum = {1'b0, hi} + (lo[0] ? {1'b0, mcand_i} : '0);
        acc_o = {sum, lo[B_W-1:1]};
    end
endmodule

// File: rtl/ptp_trim_div_step.sv
`timescale 1ns/1ps
// One restoring-division iteration: brings the next dividend bit into the
// partial remainder, subtracts the divisor when it fits, records the bit.
module ptp_trim_div_step #(
    parameter int DVD_W = 64,
    parameter int DSR_W = 32
) (
    input  logic [DSR_W-1:0] rem_i,
    input  logic [DVD_W-1:0] quo_i,
    input  logic [DSR_W-1:0] dsr_i,
    output logic [DSR_W-1:0] rem_o,
    output logic [DVD_W-1:0] quo_o
);
    logic [DSR_W:0] trial;
    logic [DSR_W:0] diff;
    logic           fits;

    always_comb begin
        trial = {rem_i, quo_i[DVD_W-1]};
        diff  = trial - {1'b0, dsr_i};
        fits  = (trial >= {1'b0, dsr_i});
        rem_o = fits ? diff[DSR_W-1:0] : trial[DSR_W-1:0];
        quo_o = {quo_i[DVD_W-2:0], fits};
    end
endmodule

// File: rtl/ptp_trim_apply.sv
`timescale 1ns/1ps
// Applies the scaled correction to the nominal increment word.
module ptp_trim_apply #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] nom_i,
    input  logic [WORD_W-1:0] adj_i,
    input  logic              neg_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        if (neg_i) word_o = nom_i - adj_i;
        else       word_o = nom_i + adj_i;
    end
endmodule

// File: rtl/ptp_inc_trimmer.sv
`timescale 1ns/1ps
module ptp_inc_trimmer
    import ptp_trim_pkg::*;
#(
    parameter int NS_W       = 8,
    parameter int FRAC_W     = 24,
    parameter int RATE_W     = 32,
    parameter int PPM_W      = 32,
    parameter int PPM_FRAC_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [PPM_W-1:0]  ppm_i,
    output logic [NS_W-1:0]   inc_ns_o,
    output logic [FRAC_W-1:0] inc_frac_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int WORD_W = NS_W + FRAC_W;
    localparam int PROD_W = PPM_W + WORD_W;
    localparam int DVD_W  = PROD_W;
    localparam int DSR_W  = RATE_W;
    localparam int CNT_W  = $clog2(DVD_W + 1);
    localparam logic [CNT_W-1:0] MUL_LAST = CNT_W'(PPM_W - 1);
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DVD_W - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic              trim;
        logic              neg;
        logic [PROD_W-1:0] acc;
        logic [DVD_W-1:0]  quo;
        logic [DSR_W-1:0]  rem;
        logic [DSR_W-1:0]  dsr;
        logic [WORD_W-1:0] nom;
        logic [WORD_W-1:0] res;
        logic              done;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    // Datapath step results
    logic [PROD_W-1:0] mul_acc_d;
    logic [DSR_W-1:0]  div_rem_d;
    logic [DVD_W-1:0]  div_quo_d;
    logic [WORD_W-1:0] trim_word_d;
    logic [PPM_W-1:0]  ppm_mag_d;
    logic [PROD_W-1:0] rounded_d;

    assign ppm_mag_d = ppm_i[PPM_W-1] ? (~ppm_i + PPM_W'(1)) : ppm_i;
    assign rounded_d = mul_acc_d + PROD_W'(ROUND_HALF);

    ptp_trim_mul_step #(
        .A_W (WORD_W),
        .B_W (PPM_W)
    ) u_mul_step (
        .acc_i   (st_q.acc),
        .mcand_i (st_q.nom),
        .acc_o   (mul_acc_d)
    );

    ptp_trim_div_step #(
        .DVD_W (DVD_W),
        .DSR_W (DSR_W)
    ) u_div_step (
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .dsr_i (st_q.dsr),
        .rem_o (div_rem_d),
        .quo_o (div_quo_d)
    );

    ptp_trim_apply #(
        .WORD_W (WORD_W)
    ) u_apply (
        .nom_i  (st_q.nom),
        .adj_i  (div_quo_d[WORD_W-1:0]),
        .neg_i  (st_q.neg),
        .word_o (trim_word_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.cnt  = '0;
                    st_d.trim = mode_i;
                    st_d.err  = 1'b0;
                    if (!mode_i) begin
                        if (rate_i == '0) begin
                            st_d.err = 1'b1;
                        end else begin
                            // Long division of 1e9 carried on into FRAC_W
                            // fractional bits: quotient is {ns, frac}.
                            st_d.ph  = PH_DIV;
                            st_d.quo = DVD_W'(NSEC_PER_SEC) << FRAC_W;
                            st_d.rem = '0;
                            st_d.dsr = DSR_W'(rate_i);
                        end
                    end else begin
                        st_d.ph  = PH_MUL;
                        st_d.neg = ppm_i[PPM_W-1];
                        st_d.acc = {{WORD_W{1'b0}}, ppm_mag_d};
                    end
                end
            end
            PH_MUL: begin
                st_d.acc = mul_acc_d;
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == MUL_LAST) begin
                    st_d.ph  = PH_DIV;
                    st_d.cnt = '0;
                    st_d.quo = DVD_W'(rounded_d >> PPM_FRAC_W);
                    st_d.rem = '0;
                    st_d.dsr = DSR_W'(SCALE_DIV);
                end
            end
            PH_DIV: begin
                st_d.quo = div_quo_d;
                st_d.rem = div_rem_d;
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == DIV_LAST) begin
                    st_d.ph   = PH_IDLE;
                    st_d.cnt  = '0;
                    st_d.done = 1'b1;
                    if (st_q.trim) begin
                        st_d.res = trim_word_d;
                    end else begin
                        st_d.res = div_quo_d[WORD_W-1:0];
                        st_d.nom = div_quo_d[WORD_W-1:0];
                    end
                end
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inc_ns_o   = st_q.res[WORD_W-1:FRAC_W];
    assign inc_frac_o = st_q.res[FRAC_W-1:0];
    assign done_o     = st_q.done;
    assign err_o      = st_q.err;

    // R7: completion is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R10: increment outputs move only together with done
    a_r10_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable({inc_ns_o, inc_frac_o}));

    // R9: a rejected request never completes
    a_r9_err_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !done_o);

    // R6: nominal word untouched while a trim is running
    a_r6_nom_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.trim && st_q.ph != PH_IDLE) |=> $stable(st_q.nom));

    // R8: the captured mode cannot change once busy
    a_r8_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph != PH_IDLE) |=> $stable(st_q.trim));

    // R2: restoring divider keeps its partial remainder below the divisor
    a_r2_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_DIV) |-> (st_q.rem < st_q.dsr));

endmodule

// File: tb/test_ptp_inc_trimmer.sv
`timescale 1ns/1ps
module test_ptp_inc_trimmer;

    localparam int INIT_LAT = 64;
    localparam int TRIM_LAT = 96;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode  = 1'b0;
    logic [31:0] rate  = '0;
    logic [31:0] ppm   = '0;
    logic [7:0]  inc_ns;
    logic [23:0] inc_frac;
    logic        done;
    logic        err;

    int     vectors     = 0;
    int     miscompares = 0;
    longint cyc         = 0;
    logic [31:0] model_nom = '0;
    logic        prev_done = 1'b0;

    typedef struct {
        logic [31:0] word;
        int          lat;
        longint      t0;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    ptp_inc_trimmer i_ptp_inc_trimmer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .mode_i     (mode),
        .rate_i     (rate),
        .ppm_i      (ppm),
        .inc_ns_o   (inc_ns),
        .inc_frac_o (inc_frac),
        .done_o     (done),
        .err_o      (err)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_init(input logic [31:0] r);
        logic [63:0] q;
        q = (64'd1000000000 << 24) / {32'd0, r};
        return q[31:0];
    endfunction

    function automatic logic [31:0] f_trim(input logic [31:0] nom, input logic [31:0] p);
        logic [63:0] mag, prod, adj, res;
        mag  = p[31] ? {32'd0, (~p + 32'd1)} : {32'd0, p};
        prod = mag * {32'd0, nom};
        adj  = ((prod + 64'd500000) >> 16) / 64'd1000000;
        res  = p[31] ? ({32'd0, nom} - adj) : ({32'd0, nom} + adj);
        return res[31:0];
    endfunction

    // Driver: pushes the expected item, then pulses start
    task automatic run_op(input bit m, input logic [31:0] r, input logic [31:0] p,
                          input string tag, input bit wait_done);
        exp_t e;
        @(negedge clk);
        e.word = m ? f_trim(model_nom, p) : f_init(r);
        e.lat  = m ? TRIM_LAT : INIT_LAT;
        e.t0   = cyc;
        e.tag  = tag;
        if (!m) model_nom = e.word;
        exp_q.push_back(e);
        mode  = m;
        rate  = r;
        ppm   = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (wait_done) begin
            while (exp_q.size() != 0) @(negedge clk);
            @(negedge clk);
        end
    endtask

    // Monitor: pops and compares on every done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) chk("R7 pulse width", 64'd1, 64'd0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " increment"}, {32'd0, inc_ns, inc_frac}, {32'd0, e.word});
                    chk({e.tag, " R7 latency"}, 64'(cyc - e.t0 - 1), 64'(e.lat));
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 64'd1, 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 inc_ns", 64'(inc_ns), 64'd0);
        chk("R1 inc_frac", 64'(inc_frac), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 err", 64'(err), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: exact division, fraction zero
        run_op(1'b0, 32'd125_000_000, '0, "R3 exact rate", 1'b1);
        chk("R3 ns field", 64'(inc_ns), 64'd8);
        chk("R3 frac field", 64'(inc_frac), 64'd0);

        // R2: inexact rates and the extremes
        run_op(1'b0, 32'd1, '0, "R2 rate one", 1'b1);
        run_op(1'b0, 32'hFFFF_FFFF, '0, "R2 rate max", 1'b1);
        run_op(1'b0, 32'd300_000_000, '0, "R2 rate 300M", 1'b1);

        // R4, R5: trims of both signs
        run_op(1'b1, '0, 32'd0, "R4 zero ppm", 1'b1);
        run_op(1'b1, '0, 32'd65536, "R4 plus one ppm", 1'b1);
        run_op(1'b1, '0, 32'h7FFF_FFFF, "R4 max positive", 1'b1);
        run_op(1'b1, '0, -32'sd65_536_000, "R5 minus 1000 ppm", 1'b1);
        run_op(1'b1, '0, 32'h8000_0000, "R5 most negative", 1'b1);

        // R6: two trims in a row, each relative to nominal
        run_op(1'b1, '0, 32'd13_107_200, "R6 first trim", 1'b1);
        run_op(1'b1, '0, 32'd3_276_800, "R6 second trim", 1'b1);

        // R8, R10: start while busy is dropped; outputs hold mid-run
        run_op(1'b0, 32'd156_250_000, '0, "R8 first op", 1'b0);
        held = f_trim(f_init(32'd300_000_000), 32'd3_276_800);
        repeat (5) @(negedge clk);
        chk("R10 outputs hold mid-run", {32'd0, inc_ns, inc_frac}, {32'd0, held});
        mode  = 1'b1;
        ppm   = 32'd9_999;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (120) @(negedge clk);
        chk("R8 result after ignored start", {32'd0, inc_ns, inc_frac},
            {32'd0, f_init(32'd156_250_000)});

        // R9: zero rate rejected
        held  = {inc_ns, inc_frac};
        mode  = 1'b0;
        rate  = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 err set", 64'(err), 64'd1);
        repeat (80) @(negedge clk);
        chk("R9 outputs unchanged", {32'd0, inc_ns, inc_frac}, {32'd0, held});
        chk("R9 err held", 64'(err), 64'd1);
        run_op(1'b1, '0, 32'd0, "R9 nominal kept", 1'b1);
        chk("R9 err cleared", 64'(err), 64'd0);

        repeat (5) @(negedge clk);
        chk("R8 no pending items", 64'(exp_q.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule